// File: doc/BRIEF.md
# Lane-Local Variable Index Shuffler

This block builds a 256-bit destination vector in which every element is copied from one of two 256-bit source vectors. Which element is copied is set by a per-element index. The index table is two sources deep and never leaves the element's own 128-bit lane. Elements can be 8, 16, 32 or 64 bits wide, and the unit runs either on the full 256 bits or on the low 128 bits only.

Indices for byte elements come from a dedicated index vector. For the wider element sizes they come from the previous destination value, which the result then replaces. The block reads every index from its inputs before forming any result element, so the destination can also act as a data source without hazard.

The shuffle network is combinational. A parameter puts a single output register stage behind it. The data path is a valid/ready stream. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. A result stays on `dst_new`, with `out_valid` high, until a clock edge where `out_ready` is high. With the register fitted, `in_ready` is high when the stage is empty or when its result leaves in the same cycle. Without the register, the handshake passes straight through.

Top module: `vec_lane_shuffle`

## Requirements
- R1: Per 128-bit lane there are m = 16, 8, 4 or 2 elements. The index of an element is the low byte of its index element, reduced modulo 2*m. Index values of 128 or more therefore act like their reduced value.
- R2: A reduced index k below m selects element k of `src_k`. Otherwise it selects element k-m of `src_j`. Both come from the same lane as the result element.
- R3: `width_sel` encodes the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits.
- R4: In 8-bit mode the indices come from `idx_vec`, and `dst_old` has no effect. In every other mode they come from `dst_old`, and `idx_vec` has no effect.
- R5: With `size_256` = 1, result elements in bits 255:128 are drawn only from bits 255:128 of the sources. No data crosses between lanes.
- R6: With `size_256` = 0, bits 255:128 of the result are zero, and the upper halves of all inputs have no effect.
- R7: The result depends only on the input values present at acceptance. This holds when `dst_old` carries the same value as `src_k` or `src_j`.
- R8: In the registered variant, a result accepted on a clock edge appears on `dst_new`, with `out_valid` high, right after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `dst_new` holds its value. `in_ready` is high whenever the output stage is empty.
- R10: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operands are valid |
| in_ready | output | 1 | Block can take an input this cycle |
| width_sel | input | 2 | Element width code (R3) |
| size_256 | input | 1 | 1: full 256-bit operation, 0: low 128 bits only |
| src_j | input | 256 | First source; selected by reduced indices m..2m-1 |
| src_k | input | 256 | Second source; selected by reduced indices 0..m-1 |
| idx_vec | input | 256 | Index vector for 8-bit elements |
| dst_old | input | 256 | Previous destination, index source for wider elements |
| out_valid | output | 1 | Result on dst_new is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| dst_new | output | 256 | Shuffled result vector |

## Verification
Two events can land on the same clock edge: the output stage hands a result to the consumer, and it takes a new operand set in its place. This is provoked by holding `in_valid` high with queued work while `out_ready` is driven high and low at random. Every edge where both handshakes fire must therefore move exactly one result out and one in. This is judged by a queue of model results. Every result that leaves is compared, in order, with the model value computed when its input was accepted, so a lost, duplicated or stale vector shows up as a mismatch. Stalled cycles are also checked to show that the held result does not change.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_w_e;

  localparam int NUM_WIDTHS = 4;
  localparam int MIN_EW     = 8;
endpackage

// File: rtl/vshuf_idx_pick.sv
module vshuf_idx_pick
  import vshuf_pkg::*;
#(
  parameter int DW = 256
) (
  input  logic [1:0]    width_sel,
  input  logic [DW-1:0] idx_vec,
  input  logic [DW-1:0] dst_old,
  output logic [DW-1:0] idx_out
);
  elem_w_e w;
  assign w = elem_w_e'(width_sel);

  // byte elements carry a separate index operand; wider ones reuse the old destination
  always_comb begin
    if (w == EW_8) idx_out = idx_vec;
    else           idx_out = dst_old;
  end
endmodule

// File: rtl/vshuf_lane.sv
module vshuf_lane
  import vshuf_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic [1:0]        width_sel,
  input  logic [LANE_W-1:0] src_j,
  input  logic [LANE_W-1:0] src_k,
  input  logic [LANE_W-1:0] idx,
  output logic [LANE_W-1:0] res
);
  // two-source table: k operand at the bottom, j operand on top
  logic [2*LANE_W-1:0] tbl;
  assign tbl = {src_j, src_k};

  generate
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_w
      localparam int EW = MIN_EW << g;
      localparam int M  = LANE_W / EW;
      localparam int IW = $clog2(2 * M);
      logic [LANE_W-1:0] r;
      logic [IW-1:0]     sel_v;
      always_comb begin
        r     = '0;
        sel_v = '0;
        for (int e = 0; e < M; e++) begin
          // modulo 2*m of a power of two keeps only the low IW bits
          sel_v = idx[e*EW +: IW];
          r[e*EW +: EW] = tbl[int'(sel_v)*EW +: EW];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (elem_w_e'(width_sel))
      EW_8:    res = g_w[0].r;
      EW_16:   res = g_w[1].r;
      EW_32:   res = g_w[2].r;
      default: res = g_w[3].r;
    endcase
  end
endmodule

// File: rtl/vshuf_out_stage.sv
module vshuf_out_stage #(
  parameter int DW      = 256,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  generate
    if (OUT_REG) begin : g_reg
      logic          v_q;
      logic [DW-1:0] d_q;
      logic          take;
      assign in_ready = !v_q || out_ready;
      assign take     = in_valid && in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         v_q <= 1'b0;
        else if (in_ready)  v_q <= in_valid;
      end

      always_ff @(posedge clk) begin
        if (take) d_q <= in_data;
      end

      assign out_valid = v_q;
      assign out_data  = d_q;
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/vec_lane_shuffle.sv
module vec_lane_shuffle
  import vshuf_pkg::*;
#(
  parameter int LANE_W    = 128,
  parameter int NUM_LANES = 2,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [1:0]                  width_sel,
  input  logic                        size_256,
  input  logic [LANE_W*NUM_LANES-1:0] src_j,
  input  logic [LANE_W*NUM_LANES-1:0] src_k,
  input  logic [LANE_W*NUM_LANES-1:0] idx_vec,
  input  logic [LANE_W*NUM_LANES-1:0] dst_old,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANE_W*NUM_LANES-1:0] dst_new
);
  localparam int DW = LANE_W * NUM_LANES;

  logic [DW-1:0] idx_all;
  logic [DW-1:0] shuf;

  vshuf_idx_pick #(.DW(DW)) u_idx (
    .width_sel (width_sel),
    .idx_vec   (idx_vec),
    .dst_old   (dst_old),
    .idx_out   (idx_all)
  );

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_res;
      vshuf_lane #(.LANE_W(LANE_W)) u_lane (
        .width_sel (width_sel),
        .src_j     (src_j[l*LANE_W +: LANE_W]),
        .src_k     (src_k[l*LANE_W +: LANE_W]),
        .idx       (idx_all[l*LANE_W +: LANE_W]),
        .res       (lane_res)
      );
      if (l == 0) begin : g_base
        assign shuf[l*LANE_W +: LANE_W] = lane_res;
      end else begin : g_upper
        assign shuf[l*LANE_W +: LANE_W] = size_256 ? lane_res : '0;
      end
    end
  endgenerate

  vshuf_out_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (shuf),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (dst_new)
  );
endmodule

// File: rtl/vec_lane_shuffle_chk.sv
module vec_lane_shuffle_chk #(
  parameter int LANE_W    = 128,
  parameter int NUM_LANES = 2,
  parameter bit OUT_REG   = 1'b1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        size_256,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [LANE_W*NUM_LANES-1:0] dst_new
);
  localparam int DW = LANE_W * NUM_LANES;

  generate
    if (OUT_REG) begin : g_reg
      logic sz_cap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    sz_cap <= 1'b1;
        else if (in_valid && in_ready) sz_cap <= size_256;
      end

      // R9: empty stage always accepts
      p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      // R9: stalled result is held unchanged
      p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(dst_new));

      // R8: an accepted input is presented on the next cycle
      p_fill_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

      // R6: narrow operations leave the upper half at zero
      p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !sz_cap |-> dst_new[DW-1:LANE_W] == '0);
    end else begin : g_pass
      p_pass_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);
      p_pass_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !size_256 |-> dst_new[DW-1:LANE_W] == '0);
      p_stall_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    end
  endgenerate
endmodule

bind vec_lane_shuffle vec_lane_shuffle_chk #(
  .LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .OUT_REG(OUT_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .size_256  (size_256),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .dst_new   (dst_new)
);

// File: tb/vec_lane_shuffle_tb.sv
`timescale 1ns/100ps
module vec_lane_shuffle_tb;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    width_sel = 2'd0;
  logic          size_256 = 1'b1;
  logic [DW-1:0] src_j = '0, src_k = '0, idx_vec = '0, dst_old = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] dst_new;

  always #2.5 clk = ~clk;

  vec_lane_shuffle u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .width_sel(width_sel), .size_256(size_256), .src_j(src_j), .src_k(src_k),
    .idx_vec(idx_vec), .dst_old(dst_old), .out_valid(out_valid),
    .out_ready(out_ready), .dst_new(dst_new)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  // pending transaction
  logic          has_pend = 1'b0;
  logic [DW-1:0] p_j, p_k, p_idx, p_old;
  logic [1:0]    p_w;
  logic          p_sz;
  string         p_tag;
  int            ready_mode = 1; // 0 random, 1 always, 2 never

  function automatic logic [DW-1:0] model(input logic [DW-1:0] j, k, ix, od,
                                          input logic [1:0] w, input logic sz);
    logic [DW-1:0] r = '0;
    logic [DW-1:0] isrc = (w == 2'd0) ? ix : od;
    int ew = 8 << w;
    int m  = 128 / ew;
    for (int l = 0; l < 2; l++) begin
      for (int e = 0; e < m; e++) begin
        int base = l*128 + e*ew;
        int iv   = int'(isrc[base +: 8]) % (2*m);
        for (int b = 0; b < ew; b++) begin
          if (iv < m) r[base+b] = k[l*128 + iv*ew + b];
          else        r[base+b] = j[l*128 + (iv-m)*ew + b];
        end
      end
    end
    if (!sz) r[255:128] = '0;
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd256();
    logic [DW-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    case (ready_mode)
      0: out_ready = $urandom_range(0, 1) == 1;
      1: out_ready = 1'b1;
      default: out_ready = 1'b0;
    endcase
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R8 unexpected output", {255'd0, out_valid}, '0);
      else check(tag_q.pop_front(), dst_new, exp_q.pop_front());
    end
    if (has_pend) begin
      in_valid = 1'b1;
      src_j = p_j; src_k = p_k; idx_vec = p_idx; dst_old = p_old;
      width_sel = p_w; size_256 = p_sz;
      #0.1;
      if (in_ready) begin
        exp_q.push_back(model(p_j, p_k, p_idx, p_old, p_w, p_sz));
        tag_q.push_back(p_tag);
        has_pend = 1'b0;
      end
    end else begin
      in_valid = 1'b0;
    end
    @(posedge clk);
  endtask

  task automatic send(input string tag, input logic [DW-1:0] j, k, ix, od,
                      input logic [1:0] w, input logic sz);
    p_j = j; p_k = k; p_idx = ix; p_old = od; p_w = w; p_sz = sz; p_tag = tag;
    has_pend = 1'b1;
    while (has_pend) tick();
  endtask

  task automatic drain();
    ready_mode = 1;
    while (exp_q.size() != 0) tick();
    tick();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, c, held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 out_valid after reset", {255'd0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 in_ready when empty", {255'd0, in_ready}, {255'd0, 1'b1});

    // R2: index 0 -> k element 0, index m -> j element 0 (bytes, m=16)
    a = rnd256(); b = rnd256();
    c = '0; c[15:8] = 8'd16;
    send("R2 low pick from k / high pick from j", a, b, c, rnd256(), 2'd0, 1'b1);
    drain();
    // R1: byte indices 200 (mod 32 = 8) and 255 (mod 32 = 31)
    c = {32{8'd200}}; c[7:0] = 8'd255;
    send("R1 index above 127 reduced", rnd256(), rnd256(), c, rnd256(), 2'd0, 1'b1);
    // R3: each width code on the same operands
    a = rnd256(); b = rnd256(); c = rnd256();
    for (int w = 0; w < 4; w++) send("R3 width code", a, b, c, c, 2'(w), 1'b1);
    drain();
    // R4: idx_vec ignored in wide mode, dst_old ignored in byte mode
    a = rnd256(); b = rnd256(); c = rnd256();
    send("R4 idx_vec ignored in 32-bit mode", a, b, '0, c, 2'd2, 1'b1);
    send("R4 idx_vec ignored in 32-bit mode", a, b, '1, c, 2'd2, 1'b1);
    send("R4 dst_old ignored in byte mode", a, b, c, '0, 2'd0, 1'b1);
    send("R4 dst_old ignored in byte mode", a, b, c, '1, 2'd0, 1'b1);
    drain();
    // R5: upper lane indices 0 must take upper-lane k element, not lower
    a = rnd256(); b = rnd256();
    send("R5 upper lane isolation", a, b, '0, '0, 2'd3, 1'b1);
    send("R5 upper lane isolation 16-bit", a, b, '0, {16{16'd9}}, 2'd1, 1'b1);
    // R6: narrow size zeroes upper half regardless of upper inputs
    send("R6 narrow upper zero", rnd256(), rnd256(), rnd256(), rnd256(), 2'd0, 1'b0);
    send("R6 narrow upper zero", '1, '1, '1, '1, 2'd3, 1'b0);
    // R7: destination doubles as a data source
    a = rnd256(); b = rnd256();
    send("R7 dst_old equals src_k", a, b, '0, b, 2'd1, 1'b1);
    send("R7 dst_old equals src_j", a, b, '0, a, 2'd2, 1'b1);
    drain();

    // R8: one-cycle latency from an empty stage
    ready_mode = 2;
    send("R8 latency data", rnd256(), rnd256(), rnd256(), rnd256(), 2'd2, 1'b1);
    @(negedge clk); #1;
    check("R8 out_valid after accept", {255'd0, out_valid}, {255'd0, 1'b1});
    // R9: stall holds data and blocks input
    held = dst_new;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R9 stalled valid held", {255'd0, out_valid}, {255'd0, 1'b1});
      check("R9 stalled data held", dst_new, held);
      check("R9 in_ready low when full and stalled", {255'd0, in_ready}, '0);
    end
    drain();

    // random traffic with random back-pressure: simultaneous in/out handoff
    ready_mode = 0;
    for (int t = 0; t < 400; t++) begin
      logic [DW-1:0] rj = rnd256(), rk = rnd256(), ri = rnd256(), ro;
      ro = ($urandom_range(0, 3) == 0) ? rk : rnd256();
      send("R2 random", rj, rk, ri, ro, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule